// File: doc/BRIEF.md
# I2C Interrupt Flag Controller

This block keeps the thirteen interrupt status flags of an I2C peripheral. The protocol engine reports each event with a one-cycle pulse, and that pulse sets the matching flag. The flag then stays set until its own clearing action occurs. Depending on the flag, that action is a read of the receive data register, a write of the transmit data register, a write-one-to-clear bit in a clear register, or a particular kind of control-register write. The register decoder supplies these actions as strobes and data. The flag vector is visible at a port so that the status register can show it.

Seven enable bits gate the flags. Some enable bits cover more than one flag. The gated flags are then merged into interrupt lines, and the `SPLIT_LINES` parameter picks the layout. With one layout, a single global line carries every source. With the other, one line carries the transfer events and a second line carries the error conditions. Each interrupt line is a registered level.

Top module: `i2c_irq_flags`

## Requirements
- R1: Flag positions in `flags`, `ev_pulse` and `clr_data` are: 0 receive-not-empty, 1 transmit-request, 2 stop-seen, 3 transfer-complete-reload, 4 transfer-complete, 5 address-match, 6 NACK-seen, 7 bus-error, 8 arbitration-lost, 9 overrun/underrun, 10 PEC-error, 11 timeout, 12 alert. A pulse on `ev_pulse[k]` sets `flags[k]` at the next clock edge, and the flag then holds until its own clearing action.
- R2: If a set pulse and a clearing action for the same flag occur in the same cycle, the flag ends up set.
- R3: `rd_rxdata` clears flag 0 and `wr_txdata` clears flag 1.
- R4: When `clr_wr` is high, a 1 in `clr_data` at bit 2 or at bits 5 to 12 clears that flag. A 0 bit in `clr_data` has no effect. Bits 0, 1, 3 and 4 of `clr_data` are ignored.
- R5: Flag 3 clears on a `ctl_wr` whose `ctl_count` is nonzero. A `ctl_wr` whose `ctl_count` is zero leaves flag 3 set.
- R6: Flag 4 clears on a `ctl_wr` that has `ctl_start` or `ctl_stop` at 1. A `ctl_wr` with both of them at 0 leaves flag 4 set.
- R7: The enable bits in `irq_en` map to flags as follows:
  - bit 0 gates flag 0
  - bit 1 gates flag 1
  - bit 2 gates flag 2
  - bit 3 gates flags 3 and 4
  - bit 4 gates flag 5
  - bit 5 gates flag 6
  - bit 6 gates flags 7 to 12
- R8: With `SPLIT_LINES`=1:
  - `irq_event` is the OR of gated flags 0 to 6.
  - `irq_error` is the OR of gated flags 7 to 12.
  - `irq_global` stays 0.

  With `SPLIT_LINES`=0:
  - `irq_global` is the OR of all gated flags.
  - `irq_event` and `irq_error` stay 0.
- R9: Each interrupt line is registered. It reflects `flags` and `irq_en` as they stood in the previous cycle, so it rises two cycles after an event pulse.
- R10: A clock edge with `rst_n` low clears all flags and all interrupt lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_pulse | input | 13 | One-cycle set pulses from the protocol engine, one per flag |
| rd_rxdata | input | 1 | Strobe: receive data register read |
| wr_txdata | input | 1 | Strobe: transmit data register written |
| clr_wr | input | 1 | Strobe: clear register written |
| clr_data | input | 13 | Write-one-to-clear data for the clear register |
| ctl_wr | input | 1 | Strobe: control register written |
| ctl_count | input | COUNT_W | Byte-count field of the control write |
| ctl_start | input | 1 | Start-request bit of the control write |
| ctl_stop | input | 1 | Stop-request bit of the control write |
| irq_en | input | 7 | Interrupt enable bits |
| flags | output | 13 | Current flag vector |
| irq_global | output | 1 | Combined interrupt line (single-line layout) |
| irq_event | output | 1 | Transfer-event interrupt line (split layout) |
| irq_error | output | 1 | Error interrupt line (split layout) |

## Verification
The assertions assume three things about the inputs:
- Every strobe and every event pulse has a known value at each clock edge.
- `rst_n` is held low at the first edge.
- `clr_data`, `ctl_count`, `ctl_start` and `ctl_stop` matter only while their strobe is high.

The bench meets these assumptions by driving every input on the falling edge and holding reset for several cycles before the first stimulus. It also returns every strobe and pulse to zero in any step that does not use it, while still varying the data fields freely so that it can show they are ignored without their strobe.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int NUM_FLAGS = 13;
    localparam int NUM_EN    = 7;

    // flag positions
    localparam int F_RX    = 0;
    localparam int F_TX    = 1;
    localparam int F_STOP  = 2;
    localparam int F_TCR   = 3;
    localparam int F_TC    = 4;
    localparam int F_ADDR  = 5;
    localparam int F_NACK  = 6;
    localparam int F_BERR  = 7;
    localparam int F_ARB   = 8;
    localparam int F_OVR   = 9;
    localparam int F_PEC   = 10;
    localparam int F_TOUT  = 11;
    localparam int F_ALERT = 12;

    // enable positions
    localparam int E_RX   = 0;
    localparam int E_TX   = 1;
    localparam int E_STOP = 2;
    localparam int E_TC   = 3;
    localparam int E_ADDR = 4;
    localparam int E_NACK = 5;
    localparam int E_ERR  = 6;

    localparam logic [NUM_FLAGS-1:0] W1C_MASK = 13'b1_1111_1110_0100;
    localparam logic [NUM_FLAGS-1:0] EVT_MASK = 13'b0_0000_0111_1111;
    localparam logic [NUM_FLAGS-1:0] ERR_MASK = 13'b1_1111_1000_0000;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
    } bank_state_t;

    typedef struct packed {
        logic glob;
        logic evt;
        logic err;
    } route_state_t;

    // enable bit that gates a given flag
    function automatic int en_of(input int f);
        case (f)
            F_RX:    return E_RX;
            F_TX:    return E_TX;
            F_STOP:  return E_STOP;
            F_TCR:   return E_TC;
            F_TC:    return E_TC;
            F_ADDR:  return E_ADDR;
            F_NACK:  return E_NACK;
            default: return E_ERR;
        endcase
    endfunction

endpackage

// File: rtl/i2c_irq_clear_decode.sv
module i2c_irq_clear_decode
    import i2c_irq_pkg::*;
#(
    parameter int COUNT_W = 8
) (
    input  logic               rd_rxdata,
    input  logic               wr_txdata,
    input  logic               clr_wr,
    input  flag_vec_t          clr_data,
    input  logic               ctl_wr,
    input  logic [COUNT_W-1:0] ctl_count,
    input  logic               ctl_start,
    input  logic               ctl_stop,
    output flag_vec_t          clr_vec
);

    flag_vec_t w1c_hit;

    always_comb begin
        w1c_hit = clr_wr ? (clr_data & W1C_MASK) : '0;
        clr_vec = '0;
        for (int k = 0; k < NUM_FLAGS; k++) begin
            if (W1C_MASK[k]) clr_vec[k] = w1c_hit[k];
        end
        clr_vec[F_RX]  = rd_rxdata;
        clr_vec[F_TX]  = wr_txdata;
        clr_vec[F_TCR] = ctl_wr && (ctl_count != '0);
        clr_vec[F_TC]  = ctl_wr && (ctl_start || ctl_stop);
    end

endmodule

// File: rtl/i2c_irq_flag_bank.sv
module i2c_irq_flag_bank
    import i2c_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t ev_pulse,
    input  flag_vec_t clr_vec,
    output flag_vec_t flags
);

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set has priority over clear
        st_d.flags = ev_pulse | (st_q.flags & ~clr_vec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

endmodule

// File: rtl/i2c_irq_route.sv
module i2c_irq_route
    import i2c_irq_pkg::*;
#(
    parameter bit SPLIT_LINES = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  flag_vec_t         flags,
    input  logic [NUM_EN-1:0] irq_en,
    output logic              irq_global,
    output logic              irq_event,
    output logic              irq_error
);

    flag_vec_t    gated;
    logic         any_evt, any_err;
    route_state_t rs_d, rs_q;

    always_comb begin
        for (int k = 0; k < NUM_FLAGS; k++) begin
            gated[k] = flags[k] & irq_en[en_of(k)];
        end
        any_evt = |(gated & EVT_MASK);
        any_err = |(gated & ERR_MASK);
    end

    generate
        if (SPLIT_LINES) begin : g_split
            always_comb begin
                rs_d      = '0;
                rs_d.evt  = any_evt;
                rs_d.err  = any_err;
            end
        end else begin : g_single
            always_comb begin
                rs_d      = '0;
                rs_d.glob = any_evt | any_err;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign irq_global = rs_q.glob;
    assign irq_event  = rs_q.evt;
    assign irq_error  = rs_q.err;

endmodule

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags
    import i2c_irq_pkg::*;
#(
    parameter bit SPLIT_LINES = 1'b1,
    parameter int COUNT_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [12:0]        ev_pulse,
    input  logic               rd_rxdata,
    input  logic               wr_txdata,
    input  logic               clr_wr,
    input  logic [12:0]        clr_data,
    input  logic               ctl_wr,
    input  logic [COUNT_W-1:0] ctl_count,
    input  logic               ctl_start,
    input  logic               ctl_stop,
    input  logic [6:0]         irq_en,
    output logic [12:0]        flags,
    output logic               irq_global,
    output logic               irq_event,
    output logic               irq_error
);

    flag_vec_t clr_vec;

    i2c_irq_clear_decode #(.COUNT_W(COUNT_W)) u_clr (
        .rd_rxdata (rd_rxdata),
        .wr_txdata (wr_txdata),
        .clr_wr    (clr_wr),
        .clr_data  (clr_data),
        .ctl_wr    (ctl_wr),
        .ctl_count (ctl_count),
        .ctl_start (ctl_start),
        .ctl_stop  (ctl_stop),
        .clr_vec   (clr_vec)
    );

    i2c_irq_flag_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_pulse (ev_pulse),
        .clr_vec  (clr_vec),
        .flags    (flags)
    );

    i2c_irq_route #(.SPLIT_LINES(SPLIT_LINES)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags      (flags),
        .irq_en     (irq_en),
        .irq_global (irq_global),
        .irq_event  (irq_event),
        .irq_error  (irq_error)
    );

endmodule

// File: rtl/i2c_irq_flags_chk.sv
module i2c_irq_flags_chk
    import i2c_irq_pkg::*;
#(
    parameter bit SPLIT_LINES = 1'b1,
    parameter int COUNT_W     = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [12:0]        ev_pulse,
    input logic               rd_rxdata,
    input logic               wr_txdata,
    input logic               clr_wr,
    input logic [12:0]        clr_data,
    input logic               ctl_wr,
    input logic [COUNT_W-1:0] ctl_count,
    input logic               ctl_start,
    input logic               ctl_stop,
    input logic [6:0]         irq_en,
    input logic [12:0]        flags,
    input logic               irq_global,
    input logic               irq_event,
    input logic               irq_error
);

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse == '0 && !rd_rxdata && !wr_txdata && !clr_wr && !ctl_wr) |=> $stable(flags)); // R1

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse != '0) |=> ((flags & $past(ev_pulse)) == $past(ev_pulse))); // R2

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxdata && !ev_pulse[F_RX]) |=> !flags[F_RX]); // R3

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txdata && !ev_pulse[F_TX]) |=> !flags[F_TX]); // R3

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((flags & $past(clr_data & W1C_MASK & ~ev_pulse)) == '0)); // R4

    AST_TCR_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[F_TCR] && ctl_wr && ctl_count == '0) |=> flags[F_TCR]); // R5

    AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (ctl_start || ctl_stop) && !ev_pulse[F_TC]) |=> !flags[F_TC]); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && !irq_global && !irq_event && !irq_error)); // R10

    generate
        if (SPLIT_LINES) begin : g_split_chk
            AST_ERR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (irq_error == $past((|(flags & ERR_MASK)) && irq_en[E_ERR]))); // R9

            AST_NO_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
                !irq_global); // R8
        end else begin : g_single_chk
            AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
                (!irq_event && !irq_error)); // R8

            AST_GLOBAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_en == '0) |=> !irq_global); // R7
        end
    endgenerate

endmodule

bind i2c_irq_flags i2c_irq_flags_chk #(
    .SPLIT_LINES (SPLIT_LINES),
    .COUNT_W     (COUNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_pulse   (ev_pulse),
    .rd_rxdata  (rd_rxdata),
    .wr_txdata  (wr_txdata),
    .clr_wr     (clr_wr),
    .clr_data   (clr_data),
    .ctl_wr     (ctl_wr),
    .ctl_count  (ctl_count),
    .ctl_start  (ctl_start),
    .ctl_stop   (ctl_stop),
    .irq_en     (irq_en),
    .flags      (flags),
    .irq_global (irq_global),
    .irq_event  (irq_event),
    .irq_error  (irq_error)
);

// File: tb/test_i2c_irq_flags.sv
`timescale 1ns/1ps
module test_i2c_irq_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] ev_pulse = '0;
    logic        rd_rxdata = 1'b0, wr_txdata = 1'b0, clr_wr = 1'b0, ctl_wr = 1'b0;
    logic [12:0] clr_data = '0;
    logic [7:0]  ctl_count = '0;
    logic        ctl_start = 1'b0, ctl_stop = 1'b0;
    logic [6:0]  irq_en = '0;

    logic [12:0] flags_s, flags_g;
    logic        glob_s, evt_s, err_s, glob_g, evt_g, err_g;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    i2c_irq_flags #(.SPLIT_LINES(1'b1), .COUNT_W(8)) i_i2c_irq_flags (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .rd_rxdata(rd_rxdata),
        .wr_txdata(wr_txdata), .clr_wr(clr_wr), .clr_data(clr_data), .ctl_wr(ctl_wr),
        .ctl_count(ctl_count), .ctl_start(ctl_start), .ctl_stop(ctl_stop), .irq_en(irq_en),
        .flags(flags_s), .irq_global(glob_s), .irq_event(evt_s), .irq_error(err_s)
    );

    i2c_irq_flags #(.SPLIT_LINES(1'b0), .COUNT_W(8)) i_i2c_irq_flags_single (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .rd_rxdata(rd_rxdata),
        .wr_txdata(wr_txdata), .clr_wr(clr_wr), .clr_data(clr_data), .ctl_wr(ctl_wr),
        .ctl_count(ctl_count), .ctl_start(ctl_start), .ctl_stop(ctl_stop), .irq_en(irq_en),
        .flags(flags_g), .irq_global(glob_g), .irq_event(evt_g), .irq_error(err_g)
    );

    typedef struct {
        string       tag;
        logic [12:0] f;
        logic        e;
        logic        x;
    } exp_t;

    exp_t        sbq[$];
    logic [12:0] mf = '0;

    // driver: apply one cycle of stimulus and queue what the next edge must give
    task automatic step(input string tag, input logic [12:0] ev, input logic rd, input logic wr,
                        input logic cw, input logic [12:0] cd, input logic ctw,
                        input logic [7:0] cnt, input logic st, input logic sp,
                        input logic [6:0] en);
        logic [12:0] clr;
        exp_t        it;
        @(negedge clk);
        rst_n = 1'b1;
        ev_pulse = ev; rd_rxdata = rd; wr_txdata = wr; clr_wr = cw; clr_data = cd;
        ctl_wr = ctl_w_fix(ctw); ctl_count = cnt; ctl_start = st; ctl_stop = sp; irq_en = en;
        clr = '0;
        clr[0] = rd;
        clr[1] = wr;
        clr[3] = ctw && (cnt != 0);
        clr[4] = ctw && (st || sp);
        if (cw) clr = clr | (cd & 13'b1_1111_1110_0100);
        it.tag = tag;
        it.e = (mf[0] & en[0]) | (mf[1] & en[1]) | (mf[2] & en[2]) |
               ((mf[3] | mf[4]) & en[3]) | (mf[5] & en[4]) | (mf[6] & en[5]);
        it.x = (|mf[12:7]) & en[6];
        mf = ev | (mf & ~clr);
        it.f = mf;
        sbq.push_back(it);
    endtask

    function automatic logic ctl_w_fix(input logic v);
        return v;
    endfunction

    task automatic idle(input string tag, input logic [6:0] en);
        step(tag, '0, 0, 0, 0, '0, 0, 8'd0, 0, 0, en);
    endtask

    task automatic do_reset(input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = 1'b0;
        ev_pulse = 13'h1FFF; rd_rxdata = 0; wr_txdata = 0; clr_wr = 0; ctl_wr = 0;
        mf = '0;
        it.tag = tag; it.f = '0; it.e = 1'b0; it.x = 1'b0;
        sbq.push_back(it);
    endtask

    // monitor: compare both layouts against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sbq.size() > 0) begin
                exp_t it;
                it = sbq.pop_front();
                total++;
                if (flags_s !== it.f || flags_g !== it.f || evt_s !== it.e || err_s !== it.x ||
                    glob_s !== 1'b0 || glob_g !== (it.e | it.x) || evt_g !== 1'b0 || err_g !== 1'b0) begin
                    bad++;
                    $display("FAIL %s: flags=%h/%h evt=%b err=%b glob=%b | single glob=%b evt=%b err=%b ; expected flags=%h evt=%b err=%b glob=%b",
                             it.tag, flags_s, flags_g, evt_s, err_s, glob_s, glob_g, evt_g, err_g,
                             it.f, it.e, it.x, it.e | it.x);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        idle("R10 reset state", 7'h7F);
        idle("R10 reset state hold", 7'h7F);

        // R1 each flag set by its own pulse, enables off so lines stay low
        for (int k = 0; k < 13; k++) begin
            step("R1 set by pulse", 13'(1) << k, 0, 0, 0, '0, 0, 8'd0, 0, 0, 7'h00);
        end
        idle("R1 hold", 7'h00);
        // R4 ignored bits and zero bits
        step("R4 zero write no effect", '0, 0, 0, 1, 13'h0000, 0, 8'd0, 0, 0, 7'h00);
        step("R4 clears only own bits", '0, 0, 0, 1, 13'h1FFF, 0, 8'd0, 0, 0, 7'h00);
        idle("R4 after clear", 7'h00);
        // R5 zero count keeps reload flag, nonzero clears
        step("R5 zero count keeps", '0, 0, 0, 0, '0, 1, 8'd0, 0, 0, 7'h00);
        step("R5 nonzero count clears", '0, 0, 0, 0, '0, 1, 8'd5, 0, 0, 7'h00);
        // R6 transfer-complete: plain write keeps, start clears
        step("R6 tc set again", 13'h0010, 0, 0, 0, '0, 0, 8'd0, 0, 0, 7'h00);
        step("R6 no start/stop keeps", '0, 0, 0, 0, '0, 1, 8'd0, 0, 0, 7'h00);
        step("R6 start clears", '0, 0, 0, 0, '0, 1, 8'd0, 1, 0, 7'h00);
        step("R6 tc set", 13'h0010, 0, 0, 0, '0, 0, 8'd0, 0, 0, 7'h00);
        step("R6 stop clears", '0, 0, 0, 0, '0, 1, 8'd0, 0, 1, 7'h00);
        // R3 data register clears
        step("R3 rx read clears", '0, 1, 0, 0, '0, 0, 8'd0, 0, 0, 7'h00);
        step("R3 tx write clears", '0, 0, 1, 0, '0, 0, 8'd0, 0, 0, 7'h00);
        // R2 set beats clear
        step("R2 rx set+read", 13'h0001, 1, 0, 0, '0, 0, 8'd0, 0, 0, 7'h00);
        step("R2 w1c set+clear", 13'h0204, 0, 0, 1, 13'h0204, 0, 8'd0, 0, 0, 7'h00);
        step("R2 tcr set+count", 13'h0008, 0, 0, 0, '0, 1, 8'd3, 1, 0, 7'h00);
        // R7 enable mapping, R9 line delay
        for (int b = 0; b < 7; b++) begin
            step("R7 single enable", '0, 0, 0, 0, '0, 0, 8'd0, 0, 0, 7'(1) << b);
            idle("R7 single enable", 7'(1) << b);
        end
        step("R4 clear all", '0, 1, 1, 1, 13'h1FFF, 1, 8'd1, 1, 0, 7'h7F);
        idle("R9 lines drop", 7'h7F);
        // R8 error vs event grouping with each flag alone, R9 two-cycle rise
        for (int k = 0; k < 13; k++) begin
            step("R8 group one flag", 13'(1) << k, 0, 0, 0, '0, 0, 8'd0, 0, 0, 7'h7F);
            idle("R9 line after flag", 7'h7F);
            idle("R8 line level", 7'h7F);
            step("R8 clear", '0, 1, 1, 1, 13'h1FFF, 1, 8'd1, 0, 1, 7'h7F);
            idle("R8 line falls", 7'h7F);
        end
        // R10 mid-run reset
        step("R10 load", 13'h1FFF, 0, 0, 0, '0, 0, 8'd0, 0, 0, 7'h7F);
        idle("R10 lines up", 7'h7F);
        do_reset("R10 mid reset");
        idle("R10 after reset", 7'h7F);
        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            logic [12:0] ev;
            ev = 13'($urandom & $urandom & $urandom);
            step("R9 random mix", ev, 1'($urandom), 1'($urandom), 1'($urandom),
                 13'($urandom), 1'($urandom), 8'($urandom % 3), 1'($urandom), 1'($urandom),
                 7'($urandom));
        end
        idle("R1 end", 7'h7F);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule